// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers level-sensitive interrupt lines from peripherals into banks of 32 sources and folds them into one request line for a parent interrupt controller. Each bank keeps a 32-bit mask in which a set bit disables its source. Software changes the mask only through two write-one ports: one sets mask bits and one clears them. Software can also read the synchronized raw levels, the mask itself, and the pending set, which is the unmasked active sources.

There is no acknowledge. A handler reads the pending word of each bank in turn, services the device, and masks the source until the device drops its line. For this reason, reading any register has no side effect. At start-up, software writes all ones to each bank's set port. The mask also resets to all ones, so the request line stays low until a source is unmasked.

The register port is a simple single-cycle bus. Bank `b` occupies the 32-byte window starting at byte address `b*0x20`. The number of banks (1 or 2) is a parameter.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit of every bank reads 1, `irq_out` is 0 and `bus_rdata` is 0.
- R2: A read at in-bank offset 0x00 returns the source levels after a two-flop synchronizer. A level driven on `irq_src` is readable from the third rising edge on, and the value is shown whatever the mask.
- R3: A write to offset 0x08 sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A write to offset 0x0C clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: A read at offset 0x04 returns the current mask, where 1 means disabled.
- R6: A read at offset 0x10 returns the synchronized status AND NOT the mask. Reading it has no side effect, so repeated reads return the same value.
- R7: `irq_out` is the OR of all pending bits of all banks, registered once. It falls when the source line drops or the source is masked.
- R8: Bank `b` is addressed at byte `b*0x20 + offset`. Bit `k` of `irq_src[32*b +: 32]` is bit `k` of that bank, and each bank's mask is independent of the others.
- R9: Writes to offsets 0x00, 0x04 and 0x10 change no state.
- R10: Reads of offsets 0x08, 0x0C and of every other in-bank offset (0x01-0x03, 0x05-0x07, 0x09-0x0B, 0x0D-0x0F, 0x11-0x1F) return 0.
- R11: An access whose bank index `bus_addr[ADDR_W-1:5]` is at or above `NUM_BANKS` reads 0, and a write to it changes no state.
- R12: `bus_rdata` is registered. It carries the selected value after the rising edge that samples `bus_rd`=1, and it is 0 after an edge where `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | NUM_BANKS*32 | Level-sensitive interrupt sources, active high |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
A change on a source line reaches the status and pending reads after two rising edges, and `irq_out` after three. The bench therefore waits three falling edges after driving a source before it reads or checks the request line. A mask write takes effect at the edge that samples it, and the request line follows one edge later, so request checks after a mask write wait one extra falling edge. Each read returns its data one edge after the strobe. The driver queues the expected word when it raises `bus_rd`, and the monitor compares it at the following falling edge.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;
  localparam int unsigned SRC_PER_BANK = 32;
  localparam int unsigned WIN_BITS     = 5;   // 32-byte window per bank
  localparam logic [WIN_BITS-1:0] OFF_RAW  = 5'h00;
  localparam logic [WIN_BITS-1:0] OFF_MASK = 5'h04;
  localparam logic [WIN_BITS-1:0] OFF_MSET = 5'h08;
  localparam logic [WIN_BITS-1:0] OFF_MCLR = 5'h0C;
  localparam logic [WIN_BITS-1:0] OFF_PEND = 5'h10;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_async;
      hold_q <= meta_q;
    end
  end

  assign q_sync = hold_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import banked_irq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SRC_PER_BANK-1:0] src_raw,
  input  logic                    set_we,
  input  logic                    clr_we,
  input  logic [SRC_PER_BANK-1:0] wr_bits,
  output logic [SRC_PER_BANK-1:0] status,
  output logic [SRC_PER_BANK-1:0] mask,
  output logic [SRC_PER_BANK-1:0] pending
);
  logic [SRC_PER_BANK-1:0] mask_q;
  logic [SRC_PER_BANK-1:0] mask_d;
  logic                    mask_en;

  irq_sync2 #(.WIDTH(SRC_PER_BANK)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (src_raw),
    .q_sync  (status)
  );

  always_comb begin
    mask_en = set_we | clr_we;
    mask_d  = mask_q;
    if (set_we) mask_d = mask_q | wr_bits;
    else if (clr_we) mask_d = mask_q & ~wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask    = mask_q;
  assign pending = status & ~mask_q;

  // R3: written ones end up set in the mask
  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & $past(wr_bits)) == $past(wr_bits)));
  // R4: written ones end up cleared in the mask
  a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(wr_bits)) == '0));
  // R9: without a set or clear strobe the mask holds
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_BANKS*SRC_PER_BANK-1:0] irq_src,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_wr,
  input  logic [31:0]                       bus_wdata,
  input  logic                              bus_rd,
  output logic [31:0]                       bus_rdata,
  output logic                              irq_out
);
  localparam int unsigned BANK_W = ADDR_W - WIN_BITS;

  logic                    rst_q_n;
  logic [BANK_W-1:0]       bank_idx;
  logic [WIN_BITS-1:0]     offset;
  logic                    bank_ok;
  logic [NUM_BANKS-1:0]    set_we;
  logic [NUM_BANKS-1:0]    clr_we;
  logic [NUM_BANKS-1:0]    bank_req;
  logic [SRC_PER_BANK-1:0] status_a  [NUM_BANKS];
  logic [SRC_PER_BANK-1:0] mask_a    [NUM_BANKS];
  logic [SRC_PER_BANK-1:0] pending_a [NUM_BANKS];
  logic [31:0]             rdata_d;
  logic [31:0]             rdata_q;
  logic                    irq_d;
  logic                    irq_q;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign bank_idx = bus_addr[ADDR_W-1:WIN_BITS];
  assign offset   = bus_addr[WIN_BITS-1:0];
  assign bank_ok  = (bank_idx < BANK_W'(NUM_BANKS));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel       = bus_wr && (bank_idx == BANK_W'(b));
    assign set_we[b] = sel && (offset == OFF_MSET);
    assign clr_we[b] = sel && (offset == OFF_MCLR);

    irq_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .src_raw (irq_src[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .set_we  (set_we[b]),
      .clr_we  (clr_we[b]),
      .wr_bits (bus_wdata),
      .status  (status_a[b]),
      .mask    (mask_a[b]),
      .pending (pending_a[b])
    );

    assign bank_req[b] = |pending_a[b];
  end

  // read mux: set/clear ports and holes return zero
  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_idx == BANK_W'(b)) begin
          case (offset)
            OFF_RAW:  rdata_d = status_a[b];
            OFF_MASK: rdata_d = mask_a[b];
            OFF_PEND: rdata_d = pending_a[b];
            default:  rdata_d = '0;
          endcase
        end
      end
    end
  end

  always_comb irq_d = |bank_req;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      irq_q   <= irq_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  // R7: any pending source raises the request one edge later
  a_r7_req_rise: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|bank_req) |=> irq_out);
  // R7: no pending source drops the request one edge later
  a_r7_req_fall: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(|bank_req) |=> !irq_out);
  // R12: no read strobe gives zero data
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_rd |=> (bus_rdata == '0));
  // R11: reads beyond the configured banks give zero
  a_r11_oob_read: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_rd && !bank_ok) |=> (bus_rdata == '0));
endmodule

// File: tb/banked_irq_ctrl_test.sv
`timescale 1ns/1ps
module banked_irq_ctrl_test;
  localparam int NB = 2;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NB*32-1:0] irq_src = '0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic            bus_rd = 1'b0;
  logic [31:0]     bus_rdata;
  logic            irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
    .clk (clk), .rst_n (rst_n), .irq_src (irq_src),
    .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_wdata (bus_wdata),
    .bus_rd (bus_rd), .bus_rdata (bus_rdata), .irq_out (irq_out)
  );

  always #10 clk = ~clk;

  // monitor: read data due one edge after the strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, e);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(irq_out, 1'b0, "R1 irq after reset");
    checks++;
    if (bus_rdata !== 32'h0) begin
      errors++; $display("FAIL R1: rdata actual %h expected 0", bus_rdata);
    end
    rd(8'h04, 32'hFFFF_FFFF, "R1 bank0 mask");
    rd(8'h24, 32'hFFFF_FFFF, "R1 R8 bank1 mask");
    // R12 idle zero after a read
    checks++;
    if (bus_rdata !== 32'h0) begin
      errors++; $display("FAIL R12: idle rdata actual %h expected 0", bus_rdata);
    end

    // R2 status, R6 pending while masked
    irq_src = {32'h0000_0100, 32'h8000_0011};
    settle();
    rd(8'h00, 32'h8000_0011, "R2 bank0 status");
    rd(8'h20, 32'h0000_0100, "R2 R8 bank1 status");
    rd(8'h10, 32'h0, "R6 pending masked");
    chk(irq_out, 1'b0, "R7 masked no request");

    // R4 clear, R5 mask read, R6 repeat read, R7 request
    wr(8'h0C, 32'h0000_0001);
    rd(8'h04, 32'hFFFF_FFFE, "R4 R5 mask after clear");
    rd(8'h10, 32'h0000_0001, "R6 pending first");
    rd(8'h10, 32'h0000_0001, "R6 pending repeat");
    chk(irq_out, 1'b1, "R7 request on pending");

    // R3 set masks again, request falls
    wr(8'h08, 32'h0000_0001);
    @(negedge clk);
    chk(irq_out, 1'b0, "R7 request drops on mask");
    rd(8'h04, 32'hFFFF_FFFF, "R3 mask after set");

    // R3/R4 zero bits leave others unchanged
    wr(8'h0C, 32'h0000_00F0);
    wr(8'h08, 32'h0000_0080);
    rd(8'h04, 32'hFFFF_FF8F, "R3 partial set");
    wr(8'h0C, 32'h0);
    rd(8'h04, 32'hFFFF_FF8F, "R4 zero clear no change");
    rd(8'h10, 32'h0000_0010, "R6 pending partial");

    // R9 writes to read-only offsets
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h10, 32'h0);
    rd(8'h04, 32'hFFFF_FF8F, "R9 mask unchanged");
    rd(8'h00, 32'h8000_0011, "R9 status unchanged");

    // R10 write ports and holes read zero
    rd(8'h08, 32'h0, "R10 set port read");
    rd(8'h0C, 32'h0, "R10 clear port read");
    rd(8'h14, 32'h0, "R10 hole 0x14");
    rd(8'h02, 32'h0, "R10 hole 0x02");
    rd(8'h3C, 32'h0, "R10 bank1 hole 0x1C");

    // R8 bank1 independent
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h24, 32'h0, "R8 bank1 mask cleared");
    rd(8'h04, 32'hFFFF_FFFF, "R8 bank0 mask untouched");
    rd(8'h30, 32'h0000_0100, "R8 bank1 pending");
    chk(irq_out, 1'b1, "R7 request from bank1");
    irq_src[63:32] = 32'h0;
    settle();
    chk(irq_out, 1'b0, "R7 request falls with source");
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h24, 32'hFFFF_FFFF, "R3 startup mask all");

    // R11 out-of-range bank
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'hEC, 32'hFFFF_FFFF);
    rd(8'h04, 32'hFFFF_FFFF, "R11 bank0 mask after oob write");
    rd(8'h24, 32'hFFFF_FFFF, "R11 bank1 mask after oob write");
    rd(8'h44, 32'h0, "R11 oob mask read");
    rd(8'h60, 32'h0, "R11 oob status read");
    @(negedge clk);
    chk(irq_out, 1'b0, "R11 no request after oob write");

    // R2 status shown while masked
    irq_src[31:0] = 32'hA5A5_A5A5;
    settle();
    rd(8'h00, 32'hA5A5_A5A5, "R2 status under mask");
    rd(8'h10, 32'h0, "R6 pending fully masked");

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule